// File: doc/BRIEF.md
# Display Data Channel Byte FIFO with Threshold Requests

This block is the byte buffer and status logic that sits between the register side of a display data channel master and its serial engine. Software pushes bytes for a write transfer, and the engine drains them. For a read transfer the engine fills the buffer and software drains it. A sticky status word reports transfer completion, bus errors, buffer overflow and underflow. It also carries a FIFO-request flag that is raised while the fill level is on the "service me" side of a programmable threshold.

Two build-time options set the variant. `INCLUSIVE_THR` picks the comparison. When it is 0, a read requests service when the level is strictly above the RX threshold, and a write requests service when the level is strictly below the TX threshold. When it is 1, both comparisons include equality. `HAS_DIR_CTRL` decides where the transfer direction comes from. When it is 1, software writes the direction. When it is 0, the direction is taken from the command type at each accepted start.

A transfer begins with a start strobe that loads the byte counter from the requested length. The busy flag stays high while the command runs. It drops on the same edge that raises the completion bit.

Top module: `ddc_fifo_ctrl`

## Requirements
- R1: The buffer holds up to DEPTH (default 16) bytes in first-in first-out order. `level` gives the current occupancy, and `rd_data` shows the oldest byte.
- R2: A push while full sets status bit 2 (overflow) and a pop while empty sets status bit 3 (underflow). In both cases the stored data and the level are left unchanged.
- R3: With exclusive comparison, status bit 8 (FIFO request) is set one edge after a cycle in which busy is high and either (read direction and level > RX threshold) or (write direction and level < TX threshold).
- R4: With inclusive comparison the same conditions use >= for read and <= for write.
- R5: Writing 1 to bit 8 clears it on that edge. If the request condition still holds, the bit is set again on the following edge.
- R6: Status bit 0 (complete), bit 1 (bus error from `eng_err`), bit 2 and bit 3 are sticky until 1 is written to them. A set event in the same cycle wins over the clear. Bits 7:4 always read 0.
- R7: A `fifo_clear` strobe makes `clear_busy` read 1 for exactly one cycle. On the next edge the buffer is emptied and `clear_busy` returns to 0.
- R8: A start while idle loads `byte_cnt` from `byte_len` and raises `busy`. Each accepted engine byte decrements the counter. A start while busy is ignored.
- R9: When the accepted engine byte takes the counter from 1 to 0, `busy` drops and status bit 0 sets on that same edge. A start with length 0 completes on the edge after the start.
- R10: Software pushes are accepted only in the write direction and software pops only in the read direction. Engine pushes are accepted only while busy in the read direction, and engine pops only while busy in the write direction. All other strobes are ignored.
- R11: When direction control is absent, the direction is taken from `cmd_read` at each accepted start (1 = read).
- R12: After reset the status is 0, the buffer is empty, and `busy`, `clear_busy` and `byte_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load both threshold fields |
| cfg_tx_thr | input | THR_W | TX (write-direction) threshold |
| cfg_rx_thr | input | THR_W | RX (read-direction) threshold |
| fifo_clear | input | 1 | Start a buffer clear |
| dir_wr | input | 1 | Load direction (only with direction control) |
| dir_read | input | 1 | Direction value, 1 = read |
| start_req | input | 1 | Start a command |
| cmd_read | input | 1 | Command type, 1 = read |
| byte_len | input | CNT_W | Transfer length loaded at start |
| st_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| st_clr_mask | input | 9 | Status bits to clear |
| sw_push | input | 1 | Software byte push |
| sw_wdata | input | DW | Software push data |
| sw_pop | input | 1 | Software byte pop |
| rd_data | output | DW | Oldest byte in the buffer |
| eng_push | input | 1 | Engine byte push (received byte) |
| eng_wdata | input | DW | Engine push data |
| eng_pop | input | 1 | Engine byte pop (byte to send) |
| eng_err | input | 1 | Engine bus error event |
| status | output | 9 | Sticky status word |
| busy | output | 1 | Command running |
| clear_busy | output | 1 | Buffer clear in progress |
| level | output | $clog2(DEPTH)+1 | Buffer occupancy |
| byte_cnt | output | CNT_W | Bytes left in the command |
| dir_is_read | output | 1 | Current direction, 1 = read |

## Verification
The bench targets the exact threshold boundary. An RX level equal to the threshold must raise a request only in the inclusive variant, and a TX level equal to the threshold likewise. A design with the comparison swapped or off by one would raise the request one byte early or late. Clearing the request while its condition persists must give one cycle of 0 and then a re-assertion; a design that let set win over clear would never show the gap. The bench also covers the last-byte edge, where busy must fall exactly as completion sets, and a zero-length start, which a counter that decrements before testing would never finish. It also drives a push into a full buffer and strobes from the wrong side or direction, where a careless design would corrupt data or shift the level.

// File: rtl/ddc_fifo_pkg.sv
package ddc_fifo_pkg;
   localparam int ST_W      = 9;
   localparam int ST_DONE   = 0;
   localparam int ST_BUSERR = 1;
   localparam int ST_OVF    = 2;
   localparam int ST_UNF    = 3;
   localparam int ST_REQ    = 8;
endpackage

// File: rtl/ddc_byte_fifo.sv
module ddc_byte_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          ovf,
   output logic          unf
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign ovf     = push & full;
   assign unf     = pop & empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !clear) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ddc_req_cmp.sv
module ddc_req_cmp #(
   parameter bit INCLUSIVE = 1'b0,
   parameter int LW        = 5,
   parameter int THR_W     = 4,
   localparam int CW       = (LW > THR_W) ? LW : THR_W
) (
   input  logic [LW-1:0]    level,
   input  logic [THR_W-1:0] rx_thr,
   input  logic [THR_W-1:0] tx_thr,
   input  logic             is_read,
   output logic             hit
);
   logic [CW-1:0] lv, rx, tx;
   assign lv = CW'(level);
   assign rx = CW'(rx_thr);
   assign tx = CW'(tx_thr);

   generate
      if (INCLUSIVE) begin : g_incl
         assign hit = is_read ? (lv >= rx) : (lv <= tx);
      end else begin : g_excl
         assign hit = is_read ? (lv > rx) : (lv < tx);
      end
   endgenerate
endmodule

// File: rtl/ddc_xfer_ctl.sv
module ddc_xfer_ctl #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   input  logic             move,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             start_acc,
   output logic             done
);
   assign start_acc = start & ~busy;
   assign done      = busy & ((cnt == '0) | (move & (cnt == CNT_W'(1))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start_acc) begin
         busy <= 1'b1;
         cnt  <= len;
      end else if (busy) begin
         if (move && cnt != '0) cnt <= cnt - 1'b1;
         if (done) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/ddc_fifo_ctrl.sv
module ddc_fifo_ctrl
   import ddc_fifo_pkg::*;
#(
   parameter int DW            = 8,
   parameter int DEPTH         = 16,
   parameter int THR_W         = 4,
   parameter int CNT_W         = 10,
   parameter bit INCLUSIVE_THR = 1'b0,
   parameter bit HAS_DIR_CTRL  = 1'b1,
   localparam int LW           = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [THR_W-1:0] cfg_tx_thr,
   input  logic [THR_W-1:0] cfg_rx_thr,
   input  logic             fifo_clear,
   input  logic             dir_wr,
   input  logic             dir_read,
   input  logic             start_req,
   input  logic             cmd_read,
   input  logic [CNT_W-1:0] byte_len,
   input  logic             st_clr_wr,
   input  logic [ST_W-1:0]  st_clr_mask,
   input  logic             sw_push,
   input  logic [DW-1:0]    sw_wdata,
   input  logic             sw_pop,
   output logic [DW-1:0]    rd_data,
   input  logic             eng_push,
   input  logic [DW-1:0]    eng_wdata,
   input  logic             eng_pop,
   input  logic             eng_err,
   output logic [ST_W-1:0]  status,
   output logic             busy,
   output logic             clear_busy,
   output logic [LW-1:0]    level,
   output logic [CNT_W-1:0] byte_cnt,
   output logic             dir_is_read
);
   generate
      if ((1 << (LW - 1)) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DW < 1 || CNT_W < 1 || THR_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   logic [THR_W-1:0] rx_thr_q, tx_thr_q;
   logic             dir_q, clear_q;
   logic             sw_push_g, sw_pop_g, eng_push_g, eng_pop_g;
   logic             push, pop, full, empty, ovf, unf, move;
   logic             start_acc, done, req_hit;
   logic [DW-1:0]    din;
   logic [ST_W-1:0]  st_q, set_vec, clr_vec;

   // direction gating
   assign sw_push_g  = sw_push & ~dir_q;
   assign sw_pop_g   = sw_pop & dir_q;
   assign eng_push_g = eng_push & busy & dir_q;
   assign eng_pop_g  = eng_pop & busy & ~dir_q;
   assign push       = sw_push_g | eng_push_g;
   assign pop        = sw_pop_g | eng_pop_g;
   assign din        = dir_q ? eng_wdata : sw_wdata;
   assign move       = (eng_push_g & ~full) | (eng_pop_g & ~empty);

   ddc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .clear(clear_q),
      .push(push), .din(din), .pop(pop), .dout(rd_data),
      .level(level), .full(full), .empty(empty), .ovf(ovf), .unf(unf)
   );

   ddc_xfer_ctl #(.CNT_W(CNT_W)) i_xfer (
      .clk(clk), .rst_n(rst_n), .start(start_req), .len(byte_len),
      .move(move), .busy(busy), .cnt(byte_cnt),
      .start_acc(start_acc), .done(done)
   );

   ddc_req_cmp #(.INCLUSIVE(INCLUSIVE_THR), .LW(LW), .THR_W(THR_W)) i_cmp (
      .level(level), .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
      .is_read(dir_q), .hit(req_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_thr_q <= '0;
         tx_thr_q <= '0;
         dir_q    <= 1'b0;
         clear_q  <= 1'b0;
      end else begin
         if (cfg_wr) begin
            rx_thr_q <= cfg_rx_thr;
            tx_thr_q <= cfg_tx_thr;
         end
         if (HAS_DIR_CTRL && dir_wr)         dir_q <= dir_read;
         else if (!HAS_DIR_CTRL && start_acc) dir_q <= cmd_read;
         clear_q <= fifo_clear & ~clear_q;
      end
   end

   // sticky status, write one to clear
   always_comb begin
      set_vec            = '0;
      set_vec[ST_DONE]   = done;
      set_vec[ST_BUSERR] = eng_err;
      set_vec[ST_OVF]    = ovf;
      set_vec[ST_UNF]    = unf;
      clr_vec            = st_clr_wr ? st_clr_mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q         <= (st_q & ~clr_vec) | set_vec;
         st_q[ST_REQ] <= clr_vec[ST_REQ] ? 1'b0 : (st_q[ST_REQ] | (busy & req_hit));
      end
   end

   assign status      = st_q;
   assign clear_busy  = clear_q;
   assign dir_is_read = dir_q;
endmodule

// File: rtl/ddc_fifo_ctrl_chk.sv
module ddc_fifo_ctrl_chk
   import ddc_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LW    = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_req,
   input logic            st_clr_wr,
   input logic [ST_W-1:0] st_clr_mask,
   input logic [ST_W-1:0] status,
   input logic            busy,
   input logic            clear_busy,
   input logic [LW-1:0]   level
);
   assert_level_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   assert_req_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr_wr && st_clr_mask[ST_REQ]) |=> !status[ST_REQ]);

   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status[7:4] == 4'b0);

   assert_clear_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_busy |=> (!clear_busy && level == '0));

   assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req) |=> busy);

   assert_done_on_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> status[ST_DONE]);
endmodule

bind ddc_fifo_ctrl ddc_fifo_ctrl_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
   .clk(clk), .rst_n(rst_n), .start_req(start_req),
   .st_clr_wr(st_clr_wr), .st_clr_mask(st_clr_mask),
   .status(status), .busy(busy), .clear_busy(clear_busy), .level(level)
);

// File: tb/test_ddc_fifo_ctrl.sv
module test_ddc_fifo_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 0, fifo_clear = 0, dir_wr = 0, dir_read = 0;
   logic [3:0] cfg_tx_thr = 0, cfg_rx_thr = 0;
   logic       start_req = 0, cmd_read = 0;
   logic [9:0] byte_len = 0;
   logic       st_clr_wr = 0;
   logic [8:0] st_clr_mask = 0;
   logic       sw_push = 0, sw_pop = 0, eng_push = 0, eng_pop = 0, eng_err = 0;
   logic [7:0] sw_wdata = 0, eng_wdata = 0;

   logic [7:0] rd_a, rd_b;
   logic [8:0] st_a, st_b;
   logic       busy_a, busy_b, clr_a, clr_b, dir_a, dir_b;
   logic [4:0] lvl_a, lvl_b;
   logic [9:0] cnt_a, cnt_b;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ddc_fifo_ctrl i_ddc_fifo_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tx_thr(cfg_tx_thr),
      .cfg_rx_thr(cfg_rx_thr), .fifo_clear(fifo_clear), .dir_wr(dir_wr),
      .dir_read(dir_read), .start_req(start_req), .cmd_read(cmd_read),
      .byte_len(byte_len), .st_clr_wr(st_clr_wr), .st_clr_mask(st_clr_mask),
      .sw_push(sw_push), .sw_wdata(sw_wdata), .sw_pop(sw_pop), .rd_data(rd_a),
      .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
      .eng_err(eng_err), .status(st_a), .busy(busy_a), .clear_busy(clr_a),
      .level(lvl_a), .byte_cnt(cnt_a), .dir_is_read(dir_a)
   );

   ddc_fifo_ctrl #(.INCLUSIVE_THR(1'b1), .HAS_DIR_CTRL(1'b0)) i_ddc_fifo_ctrl_incl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tx_thr(cfg_tx_thr),
      .cfg_rx_thr(cfg_rx_thr), .fifo_clear(fifo_clear), .dir_wr(dir_wr),
      .dir_read(dir_read), .start_req(start_req), .cmd_read(cmd_read),
      .byte_len(byte_len), .st_clr_wr(st_clr_wr), .st_clr_mask(st_clr_mask),
      .sw_push(sw_push), .sw_wdata(sw_wdata), .sw_pop(sw_pop), .rd_data(rd_b),
      .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
      .eng_err(eng_err), .status(st_b), .busy(busy_b), .clear_busy(clr_b),
      .level(lvl_b), .byte_cnt(cnt_b), .dir_is_read(dir_b)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic w1c(input logic [8:0] m);
      st_clr_wr = 1; st_clr_mask = m; cyc(1); st_clr_wr = 0; st_clr_mask = 0;
   endtask

   task automatic set_dir(input logic rd);
      dir_wr = 1; dir_read = rd; cyc(1); dir_wr = 0;
   endtask

   task automatic set_thr(input logic [3:0] tx, input logic [3:0] rx);
      cfg_wr = 1; cfg_tx_thr = tx; cfg_rx_thr = rx; cyc(1); cfg_wr = 0;
   endtask

   task automatic start(input logic rd, input int len);
      start_req = 1; cmd_read = rd; byte_len = 10'(len); cyc(1); start_req = 0;
   endtask

   task automatic swp(input logic [7:0] d);
      sw_push = 1; sw_wdata = d; cyc(1); sw_push = 0;
   endtask

   task automatic engp(input logic [7:0] d);
      eng_push = 1; eng_wdata = d; cyc(1); eng_push = 0;
   endtask

   task automatic do_clear();
      fifo_clear = 1; cyc(1); fifo_clear = 0;
   endtask

   task automatic t_reset();
      chk("R12", "status", st_a, 0);
      chk("R12", "level", lvl_a, 0);
      chk("R12", "busy", busy_a, 0);
      chk("R12", "clear_busy", clr_a, 0);
      chk("R12", "byte_cnt", cnt_a, 0);
   endtask

   task automatic t_tx_path();
      set_dir(0);
      set_thr(4'd1, 4'd2);
      start(0, 3);
      chk("R8", "cnt loaded", cnt_a, 3);
      cyc(1);
      chk("R3", "tx req empty", st_a[8], 1);
      chk("R4", "incl tx req empty", st_b[8], 1);
      swp(8'hA1);
      w1c(9'h100);
      chk("R5", "req cleared", st_a[8], 0);
      cyc(1);
      chk("R3", "excl tx level==thr no req", st_a[8], 0);
      chk("R4", "incl tx level==thr req", st_b[8], 1);
      swp(8'hB2); swp(8'hC3);
      chk("R1", "level 3", lvl_a, 3);
      w1c(9'h100); cyc(1);
      chk("R3", "excl tx no req at 3", st_a[8], 0);
      chk("R4", "incl tx no req at 3", st_b[8], 0);
      chk("R1", "head A1", rd_a, 8'hA1);
      eng_pop = 1; cyc(1);
      chk("R1", "head B2", rd_a, 8'hB2);
      chk("R8", "cnt 2", cnt_a, 2);
      cyc(1);
      chk("R1", "head C3", rd_a, 8'hC3);
      chk("R9", "busy before last", busy_a, 1);
      cyc(1); eng_pop = 0;
      chk("R9", "busy fell at last", busy_a, 0);
      chk("R9", "done set", st_a[0], 1);
      chk("R1", "level 0", lvl_a, 0);
   endtask

   task automatic t_rx_path();
      w1c(9'h1FF);
      set_dir(1);
      set_thr(4'd1, 4'd2);
      start(1, 4);
      chk("R11", "incl dir from cmd", dir_b, 1);
      engp(8'h10); engp(8'h20); cyc(1);
      chk("R3", "excl rx level==thr no req", st_a[8], 0);
      chk("R4", "incl rx level==thr req", st_b[8], 1);
      engp(8'h30); cyc(1);
      chk("R3", "excl rx level>thr req", st_a[8], 1);
      w1c(9'h100);
      chk("R5", "req gap", st_a[8], 0);
      cyc(1);
      chk("R5", "req reasserts", st_a[8], 1);
      chk("R1", "head 10", rd_a, 8'h10);
      sw_pop = 1; cyc(1);
      chk("R1", "head 20", rd_a, 8'h20);
      cyc(1);
      chk("R1", "head 30", rd_a, 8'h30);
      cyc(1); sw_pop = 0;
      chk("R8", "cnt 1", cnt_a, 1);
      engp(8'h40);
      chk("R9", "rx done", st_a[0], 1);
      chk("R9", "rx busy low", busy_a, 0);
      sw_pop = 1; cyc(1); sw_pop = 0;
   endtask

   task automatic t_overflow_clear();
      w1c(9'h1FF);
      set_dir(0);
      for (int i = 0; i < 16; i++) swp(8'(i + 1));
      chk("R2", "no ovf at full", st_a[2], 0);
      swp(8'hEE);
      chk("R2", "ovf set", st_a[2], 1);
      chk("R2", "level stays 16", lvl_a, 16);
      chk("R2", "head kept", rd_a, 1);
      sw_pop = 1; cyc(1); sw_pop = 0;
      chk("R10", "sw pop in write dir ignored", lvl_a, 16);
      do_clear();
      chk("R7", "clear_busy high", clr_a, 1);
      cyc(1);
      chk("R7", "clear_busy low", clr_a, 0);
      chk("R7", "level 0", lvl_a, 0);
      w1c(9'h004);
      chk("R6", "ovf cleared", st_a[2], 0);
   endtask

   task automatic t_underflow_err();
      set_dir(1);
      sw_pop = 1; cyc(1); sw_pop = 0;
      chk("R2", "unf set", st_a[3], 1);
      chk("R2", "level still 0", lvl_a, 0);
      swp(8'h55);
      chk("R10", "sw push in read dir ignored", lvl_a, 0);
      engp(8'h66);
      chk("R10", "eng push while idle ignored", lvl_a, 0);
      eng_err = 1; cyc(1); eng_err = 0;
      chk("R6", "bus err set", st_a[1], 1);
      chk("R6", "unf still set", st_a[3], 1);
      w1c(9'h00A);
      chk("R6", "w1c clears", st_a, 0);
   endtask

   task automatic t_zero_len_busy_start();
      start(1, 0);
      chk("R9", "zero len busy", busy_a, 1);
      cyc(1);
      chk("R9", "zero len done", busy_a, 0);
      chk("R9", "zero len done bit", st_a[0], 1);
      w1c(9'h001);
      start(1, 5);
      start(1, 9);
      chk("R8", "start while busy ignored", cnt_a, 5);
      engp(8'h01);
      chk("R8", "cnt dec", cnt_a, 4);
      for (int i = 0; i < 4; i++) engp(8'h02);
      chk("R9", "finished", busy_a, 0);
      do_clear(); cyc(1);
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      t_reset();
      t_tx_path();
      t_rx_path();
      t_overflow_clear();
      t_underflow_err();
      t_zero_len_busy_start();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule